// File: doc/BRIEF.md
# Halving-Tree Partial-Sum Reducer

This block collapses a bank of `N` register-held partial sums into one total. Software or an upstream engine fills the bank through a write port while the block is idle, then pulses `start`. The block walks a halving tree one level per clock. On each level, lane 0 first absorbs the element left over by an odd active count. Then every lane below half the count adds in its partner, which sits half the count above it. The reduction ends when the active count reaches one. At that point entry 0 holds the total, and a one-cycle `done` pulse marks completion.

All lanes act in the same cycle, so there is an implicit barrier between levels: a level only reads values that the previous level has fully written. Any `N` works, not only powers of two. The sum width is a parameter, and every addition wraps modulo 2^W. The result stays on `total` until the next reduction or write changes entry 0.

Top module: `prs_reduce_seq`

## Requirements
- R1: While `busy` is low, a cycle with `wr_en` high stores `wr_data` into entry `wr_idx` (entries numbered 0..N-1; an index of N or more is dropped). `total` always shows entry 0.
- R2: A `start` sampled while idle raises `busy` on the next cycle and loads the active count with N.
- R3: When the active count at a level is odd, entry 0 first adds the entry at index count-1. An odd count therefore loses no element.
- R4: On each level, let h be the count divided by two, rounded down. Every lane i < h adds entry i+h into entry i, and lane 0 uses its value after the odd fold. The count then becomes h.
- R5: Exactly one level runs per clock. `done` is high in the cycle that follows floor(log2 N)+1 clock edges after the edge that sampled `start`.
- R6: Sums wrap modulo 2^W, so the final total equals the plain sum of the loaded entries modulo 2^W.
- R7: A `start` pulse while `busy` is high is ignored. It does not change the latency or the result.
- R8: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: After `done`, `total` holds its value while no write or new start arrives.
- R10: Writes while `busy` is high are ignored and do not alter the result.
- R11: With N equal to 1, `done` is high one cycle after the sampling edge of `start`, and no addition takes place.
- R12: After reset, `busy`, `done` and `total` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for one entry (honoured only when idle) |
| wr_idx | input | max(1, clog2(N)) | Entry index to load |
| wr_data | input | W | Value to load |
| start | input | 1 | Begin a reduction (honoured only when idle) |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| total | output | W | Contents of entry 0 |

## Verification
A wrong odd-count fold or a wrong partner index loses or duplicates an entry. This shows as a bad `total` in the `done` cycle of the first run whose data are not symmetric. Directed patterns that put a single nonzero value at the top index, or in a partner slot, tie such a fault to one level. A count or halving fault moves the `done` pulse by at least one cycle, so the exact latency is compared on every run. Writes and starts issued mid-reduction would corrupt the same result, or shift the same pulse, within that run.

// File: rtl/prs_pkg.sv
package prs_pkg;
   function automatic int prs_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int prs_cnt_w(input int n);
      return (n > 1) ? $clog2(n + 1) : 1;
   endfunction
endpackage

// File: rtl/prs_round_ctrl.sv
module prs_round_ctrl #(
   parameter int N  = 11,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          round_en,
   output logic [CW-1:0] cnt
);
   logic          busy_q, done_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               cnt_q  <= CW'(N);
            end
         end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q >> 1;
         end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign cnt      = cnt_q;
   assign round_en = busy_q && (cnt_q > CW'(1));

   p_seed_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> cnt_q == CW'(N));
   p_one_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q > CW'(1)) |=> (busy_q && cnt_q == ($past(cnt_q) >> 1)));
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && cnt_q > CW'(1)) |=> cnt_q < $past(cnt_q));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (!done_q && !busy_q));
   p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> ($past(busy_q) && $past(cnt_q) == CW'(1)));
endmodule

// File: rtl/prs_lane_array.sv
module prs_lane_array #(
   parameter int N  = 11,
   parameter int W  = 16,
   parameter int CW = 4,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          round_en,
   input  logic [CW-1:0] cnt,
   input  logic          wr_ok,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   output logic [W-1:0]  total
);
   logic [W-1:0]  ent_q [N];
   logic [W-1:0]  ent_d [N];
   logic [CW-1:0] half;

   assign half = cnt >> 1;

   generate
      if (N == 1) begin : g_single
         always_comb ent_d[0] = ent_q[0];
      end else begin : g_tree
         logic [W-1:0] fold_val;

         // Odd count: pick the unpaired top entry for lane 0
         always_comb begin
            fold_val = '0;
            if (cnt[0] && cnt > CW'(1)) begin
               for (int k = 1; k < N; k++) begin
                  if (k == int'(cnt) - 1) fold_val = ent_q[k];
               end
            end
         end

         for (genvar i = 0; i < N / 2; i++) begin : g_lane
            logic [W-1:0] partner;
            logic [W-1:0] base;
            always_comb begin
               partner = '0;
               for (int k = i + 1; k < N; k++) begin
                  if (k == i + int'(half)) partner = ent_q[k];
               end
            end
            if (i == 0) begin : g_fold
               assign base = ent_q[0] + fold_val;
            end else begin : g_plain
               assign base = ent_q[i];
            end
            assign ent_d[i] = (i < int'(half)) ? base + partner : ent_q[i];
         end

         for (genvar j = N / 2; j < N; j++) begin : g_idle
            assign ent_d[j] = ent_q[j];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) ent_q[k] <= '0;
      end else if (round_en) begin
         for (int k = 0; k < N; k++) ent_q[k] <= ent_d[k];
      end else if (wr_ok) begin
         for (int k = 0; k < N; k++) begin
            if (int'(wr_idx) == k) ent_q[k] <= wr_data;
         end
      end
   end

   assign total = ent_q[0];

   p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !round_en && wr_idx == '0) |=> total == $past(wr_data));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!round_en && !wr_ok) |=> $stable(total));
   p_no_write_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(round_en && wr_ok));
endmodule

// File: rtl/prs_reduce_seq.sv
module prs_reduce_seq #(
   parameter int N = 11,
   parameter int W = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [prs_pkg::prs_idx_w(N)-1:0]  wr_idx,
   input  logic [W-1:0]                      wr_data,
   input  logic                              start,
   output logic                              busy,
   output logic                              done,
   output logic [W-1:0]                      total
);
   localparam int IW = prs_pkg::prs_idx_w(N);
   localparam int CW = prs_pkg::prs_cnt_w(N);

   generate
      if (N < 1) begin : g_bad_n
         $error("prs_reduce_seq: N must be at least 1");
      end
      if (W < 1) begin : g_bad_w
         $error("prs_reduce_seq: W must be at least 1");
      end
   endgenerate

   logic          round_en;
   logic [CW-1:0] cnt;
   logic          wr_ok;

   assign wr_ok = wr_en && !busy;

   prs_round_ctrl #(.N(N), .CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .done     (done),
      .round_en (round_en),
      .cnt      (cnt)
   );

   prs_lane_array #(.N(N), .W(W), .CW(CW), .IW(IW)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .round_en (round_en),
      .cnt      (cnt),
      .wr_ok    (wr_ok),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .total    (total)
   );

   p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (N == 1 && !busy && start) |=> ##1 done);
endmodule

// File: tb/prs_reduce_seq_tb.sv
`timescale 1ns/1ps
module prs_reduce_seq_tb;
   localparam int N  = 11;
   localparam int W  = 16;
   localparam int IW = prs_pkg::prs_idx_w(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          wr_en = 1'b0, start = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [W-1:0]  wr_data = '0;
   logic          busy, done;
   logic [W-1:0]  total;

   logic          o_wr_en = 1'b0, o_start = 1'b0;
   logic [0:0]    o_wr_idx = '0;
   logic [W-1:0]  o_wr_data = '0;
   logic          o_busy, o_done;
   logic [W-1:0]  o_total;

   prs_reduce_seq #(.N(N), .W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .start(start), .busy(busy), .done(done), .total(total));

   prs_reduce_seq #(.N(1), .W(W)) u_dut_one (
      .clk(clk), .rst_n(rst_n), .wr_en(o_wr_en), .wr_idx(o_wr_idx), .wr_data(o_wr_data),
      .start(o_start), .busy(o_busy), .done(o_done), .total(o_total));

   int n_chk = 0, n_bad = 0;
   logic [W-1:0] vals [N];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_sum();
      logic [W-1:0] s = '0;
      for (int k = 0; k < N; k++) s = s + vals[k];
      return s;
   endfunction

   function automatic int exp_lat(input int n);
      int r = 0;
      int c = n;
      while (c > 1) begin c = c / 2; r++; end
      return r + 2;
   endfunction

   task automatic load_all();
      for (int k = 0; k < N; k++) begin
         wr_en = 1'b1; wr_idx = IW'(k); wr_data = vals[k];
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   // poke: 1 = extra start mid-run (R7), 2 = write to entry 0 mid-run (R10)
   task automatic run_one(input string tag, input int poke);
      int k = 0;
      logic [W-1:0] e = exp_sum();
      load_all();
      start = 1'b1;
      while (k < 40) begin
         @(negedge clk);
         k++;
         start = 1'b0;
         wr_en = 1'b0;
         if (k == 2 && poke == 1) start = 1'b1;
         if (k == 2 && poke == 2) begin wr_en = 1'b1; wr_idx = '0; wr_data = ~e; end
         if (k == 2) check(busy == 1'b1, {"R2 busy ", tag}, busy, 1);
         if (done) break;
      end
      start = 1'b0; wr_en = 1'b0;
      check(k == exp_lat(N), {"R5 latency ", tag}, k, exp_lat(N));
      check(total == e, {"R6 total ", tag}, total, e);
      check(busy == 1'b0, {"R8 busy at done ", tag}, busy, 0);
      @(negedge clk);
      check(done == 1'b0, {"R8 pulse width ", tag}, done, 0);
      repeat (3) @(negedge clk);
      check(total == e, {"R9 hold ", tag}, total, e);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0, "R12 flags", {busy, done}, 0);
      check(total == '0, "R12 total", total, 0);

      // R1: direct load of entry 0 shows on total; out-of-range index dropped
      wr_en = 1'b1; wr_idx = '0; wr_data = 16'h0abc;
      @(negedge clk);
      wr_idx = IW'(N); wr_data = 16'h5555;
      @(negedge clk);
      wr_en = 1'b0;
      check(total == 16'h0abc, "R1 write entry0", total, 16'h0abc);

      // R3: only the unpaired top entry is nonzero
      for (int k = 0; k < N; k++) vals[k] = '0;
      vals[N-1] = 16'h0123;
      run_one("R3 top only", 0);
      // R4: only a partner slot nonzero
      for (int k = 0; k < N; k++) vals[k] = '0;
      vals[5] = 16'h0456; vals[3] = 16'h0011;
      run_one("R4 partner", 0);
      // R6: wrap
      for (int k = 0; k < N; k++) vals[k] = 16'hffff;
      run_one("R6 wrap", 0);
      // R7: start while busy
      for (int k = 0; k < N; k++) vals[k] = W'(k * 7 + 1);
      run_one("R7 start mid", 1);
      // R10: write while busy
      for (int k = 0; k < N; k++) vals[k] = W'($urandom);
      run_one("R10 write mid", 2);
      // random runs
      for (int t = 0; t < 30; t++) begin
         for (int k = 0; k < N; k++) vals[k] = W'($urandom);
         run_one("R4 random", 0);
      end

      // R11: single entry instance
      o_wr_en = 1'b1; o_wr_data = 16'h7e57;
      @(negedge clk);
      o_wr_en = 1'b0; o_start = 1'b1;
      @(negedge clk);
      o_start = 1'b0;
      check(o_done == 1'b0, "R11 no early done", o_done, 0);
      @(negedge clk);
      check(o_done == 1'b1, "R11 done timing", o_done, 1);
      check(o_total == 16'h7e57, "R11 total", o_total, 16'h7e57);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule